// File: doc/BRIEF.md
# External Memory Bus Address-Latch Sequencer

This block paces a multiplexed external memory bus for an 8-bit microcontroller. Each slot is six oscillator cycles long, set by a phase counter that runs from 0 to 5. The block drives the address-latch strobe high for the first two cycles of every slot, so the strobe free-runs at one sixth of the oscillator rate. It also tells the port-0 multiplexer when to carry the low address byte and when to carry data. It chooses the port-2 output value from the pointer width of the access in progress.

Bus cycles come in through a valid/ready request channel. A request is taken only on the last phase of a slot. The requester must hold `req_valid`, `req_kind` and `req_addr` steady until it sees `req_ready` high on a clock edge. `req_ready` does not depend on `req_valid`. An external data access, using either a 16-bit or an 8-bit pointer, takes two slots. The first slot puts out the address. The second slot moves data and leaves out its strobe pulse.

A disable bit can silence the strobe. While the bit is set, the strobe pulses only in data-move and table-read slots. It is released to a weak high at all other times. The disable bit is ignored while the external-execution flag is set.

Top module: `ale_bus_seq`

## Requirements
- R1: The strobe is high for exactly two cycles, phases 0 and 1, of each six-cycle slot in which it is enabled, and low for the other four.
- R2: `req_ready` is high only in phase 5. It stays low in phase 5 of the first slot of a data access. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high, and the slot it starts begins with phase 0 in the next cycle.
- R3: A code fetch (`req_kind`=0) or a table read (`req_kind`=3) takes one slot. In that slot `p0_sel` is 1 (address) for phases 0 to 2 and 2 (data) for phases 3 to 5. In a slot with no request, `p0_sel` is 0 (port register).
- R4: A data access with a 16-bit pointer (`req_kind`=1) or an 8-bit pointer (`req_kind`=2) takes two slots. In the first slot `p0_sel` is 1 and the strobe pulses. In the second slot `p0_sel` is 2 and the strobe is held low with `ale_oe`=1, so one pulse is dropped.
- R5: During the slots of a code fetch, a 16-bit-pointer data access or a table read, `p2_out` equals `req_addr[15:8]` of the accepted request.
- R6: During the slots of an 8-bit-pointer data access, and in slots with no request, `p2_out` equals `p2_sfr`.
- R7: With `ale_dis`=1 and `ext_exec`=0, slots with no request and code-fetch slots drive `ale_oe`=0 and `ale`=1 for all six phases.
- R8: With `ext_exec`=1, `ale_dis` has no effect and the strobe behaves as if it were enabled.
- R9: With `ale_dis`=1, data-access and table-read slots still drive the strobe as in R1 and R4, with `ale_oe`=1.
- R10: Reset restarts the phase counter at 0 with no request active. During reset the strobe is high, `req_ready` is low, `p0_sel` is 0 and `p2_out` equals `p2_sfr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus-cycle request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_kind | input | 2 | 0 code fetch, 1 data 16-bit pointer, 2 data 8-bit pointer, 3 table read |
| req_addr | input | 16 | Bus address |
| p2_sfr | input | 8 | Port-2 special register value |
| ale_dis | input | 1 | Strobe disable bit |
| ext_exec | input | 1 | External execution mode |
| ale | output | 1 | Address-latch strobe level |
| ale_oe | output | 1 | Strobe strong drive enable (0 = weak high) |
| p0_sel | output | 2 | Port-0 source: 0 port register, 1 address low, 2 data |
| p2_out | output | 8 | Port-2 output value |

## Verification
All outputs are decoded without registers from the phase counter and the slot state. Each result is therefore due in the cycle after the clock edge that moves the counter. An accepted request shows its first phase-0 outputs one cycle after the accepting edge.

The bench drives inputs and samples outputs at the falling edge. It takes each acceptance from the `req_ready` it saw at the falling edge just before. Then it checks every phase of the slot, or of both slots, against an expected pattern worked out from the request kind, the disable bit and the execution flag. The reset checks follow the counter from phase 0 through the first cycles after release.

// File: rtl/ale_seq_pkg.sv
package ale_seq_pkg;
  typedef enum logic [1:0] {
    BK_CODE   = 2'd0,
    BK_DATA16 = 2'd1,
    BK_DATA8  = 2'd2,
    BK_TABLE  = 2'd3
  } bus_kind_e;

  typedef enum logic [1:0] {
    P0_PORT = 2'd0,
    P0_ADDR = 2'd1,
    P0_DATA = 2'd2
  } p0_src_e;

  typedef struct packed {
    logic      busy;
    logic      second;
    bus_kind_e kind;
    logic [7:0] addr_hi;
  } slot_t;

  function automatic logic is_data(bus_kind_e k);
    return (k == BK_DATA16) || (k == BK_DATA8);
  endfunction
endpackage

// File: rtl/ale_phase_ctr.sv
module ale_phase_ctr #(
  parameter int PHASES = 6,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= '0;
    else if (phase == LAST_PH) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign last = (phase == LAST_PH);

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> (phase == '0));
  // R1
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= LAST_PH);
endmodule

// File: rtl/ale_slot_ctrl.sv
module ale_slot_ctrl
  import ale_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       last,
  input  logic       req_valid,
  input  bus_kind_e  req_kind,
  input  logic [7:0] req_addr_hi,
  output logic       req_ready,
  output slot_t      slot
);
  logic need_second;

  assign need_second = slot.busy && !slot.second && is_data(slot.kind);
  assign req_ready   = last && !need_second;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (last) begin
      if (need_second) begin
        slot.second <= 1'b1;
      end else if (req_valid) begin
        slot.busy    <= 1'b1;
        slot.second  <= 1'b0;
        slot.kind    <= req_kind;
        slot.addr_hi <= req_addr_hi;
      end else begin
        slot.busy   <= 1'b0;
        slot.second <= 1'b0;
      end
    end
  end

  // R4
  second_slot_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last && need_second) |=> (slot.busy && slot.second));
  // R4
  second_only_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot.second |-> (slot.busy && is_data(slot.kind)));
  // R2
  slot_stable_midway_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(slot));
endmodule

// File: rtl/ale_out_mux.sv
module ale_out_mux
  import ale_seq_pkg::*;
#(
  parameter int PHASES  = 6,
  parameter int ALE_HI  = 2,
  parameter int ADDR_PH = 3,
  localparam int PW = $clog2(PHASES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] phase,
  input  slot_t         slot,
  input  logic          ale_dis,
  input  logic          ext_exec,
  input  logic [7:0]    p2_sfr,
  output logic          ale,
  output logic          ale_oe,
  output p0_src_e       p0_sel,
  output logic [7:0]    p2_out
);
  logic strobe_win, allowed, movx_like;

  assign strobe_win = (phase < PW'(ALE_HI));
  assign movx_like  = slot.busy && (slot.kind != BK_CODE);
  assign allowed    = !ale_dis || ext_exec || movx_like;

  always_comb begin
    if (slot.busy && slot.second) begin
      ale    = 1'b0;
      ale_oe = 1'b1;
    end else if (!allowed) begin
      ale    = 1'b1;
      ale_oe = 1'b0;
    end else begin
      ale    = strobe_win;
      ale_oe = 1'b1;
    end
  end

  always_comb begin
    if (!slot.busy)                  p0_sel = P0_PORT;
    else if (slot.second)            p0_sel = P0_DATA;
    else if (is_data(slot.kind))     p0_sel = P0_ADDR;
    else if (phase < PW'(ADDR_PH))   p0_sel = P0_ADDR;
    else                             p0_sel = P0_DATA;
  end

  assign p2_out = (slot.busy && slot.kind != BK_DATA8) ? slot.addr_hi : p2_sfr;

  // R7
  weak_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ale_oe |-> (ale && ale_dis && !ext_exec));
  // R3
  addr_before_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale) && slot.busy && !slot.second) |-> (p0_sel == P0_ADDR));
endmodule

// File: rtl/ale_bus_seq.sv
module ale_bus_seq
  import ale_seq_pkg::*;
#(
  parameter int PHASES  = 6,
  parameter int ALE_HI  = 2,
  parameter int ADDR_PH = 3,
  parameter int AW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    p2_sfr,
  input  logic          ale_dis,
  input  logic          ext_exec,
  output logic          ale,
  output logic          ale_oe,
  output logic [1:0]    p0_sel,
  output logic [7:0]    p2_out
);
  localparam int PW = $clog2(PHASES);

  logic [PW-1:0] phase;
  logic          last;
  slot_t         slot;
  p0_src_e       p0_src;

  ale_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst_n(rst_n), .phase(phase), .last(last)
  );

  ale_slot_ctrl u_slot (
    .clk(clk), .rst_n(rst_n), .last(last),
    .req_valid(req_valid), .req_kind(bus_kind_e'(req_kind)),
    .req_addr_hi(req_addr[AW-1 -: 8]),
    .req_ready(req_ready), .slot(slot)
  );

  ale_out_mux #(.PHASES(PHASES), .ALE_HI(ALE_HI), .ADDR_PH(ADDR_PH)) u_mux (
    .clk(clk), .rst_n(rst_n), .phase(phase), .slot(slot),
    .ale_dis(ale_dis), .ext_exec(ext_exec), .p2_sfr(p2_sfr),
    .ale(ale), .ale_oe(ale_oe), .p0_sel(p0_src), .p2_out(p2_out)
  );

  assign p0_sel = p0_src;

  // R4
  dropped_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_sel == 2'd2 && slot.second) |-> (!ale && ale_oe));
  // R2
  ready_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (ale || !ale_oe || slot.second) && p0_sel != 2'd0);
endmodule

// File: tb/tb_ale_bus_seq.sv
module tb_ale_bus_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] p2_sfr = 8'h5A;
  logic ale_dis = 1'b0, ext_exec = 1'b0;
  logic ale, ale_oe;
  logic [1:0] p0_sel;
  logic [7:0] p2_out;
  int total = 0, failed = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ale_bus_seq dut (.*);

  // {kind, addr, sfr, dis, ext}
  localparam int NV = 8;
  localparam logic [27:0] VEC [NV] = '{
    {2'd0, 16'h12A4, 8'h33, 1'b0, 1'b0},
    {2'd1, 16'hBEEF, 8'h44, 1'b0, 1'b0},
    {2'd2, 16'h7781, 8'hC3, 1'b0, 1'b0},
    {2'd3, 16'h9A10, 8'h01, 1'b0, 1'b0},
    {2'd0, 16'h4321, 8'h22, 1'b1, 1'b0},
    {2'd1, 16'hF00D, 8'h66, 1'b1, 1'b0},
    {2'd3, 16'h0C0C, 8'h99, 1'b1, 1'b0},
    {2'd0, 16'hE5E5, 8'h10, 1'b1, 1'b1}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected outputs for one phase; busy=0 means slot with no request
  task automatic check_phase(bit busy, logic [1:0] kind, bit second, int ph,
                             logic [7:0] ahi);
    bit en;
    logic e_ale, e_oe;
    logic [1:0] e_p0;
    en = !ale_dis || ext_exec || (busy && kind != 2'd0);
    if (busy && second) begin e_ale = 0; e_oe = 1; end
    else if (!en) begin e_ale = 1; e_oe = 0; end
    else begin e_ale = (ph < 2); e_oe = 1; end
    if (!busy) e_p0 = 0;
    else if (second) e_p0 = 2;
    else if (kind == 1 || kind == 2) e_p0 = 1;
    else e_p0 = (ph < 3) ? 2'd1 : 2'd2;
    check(busy ? (ale_dis && !ext_exec ? "R9 ale" : "R1 ale") :
          (ale_dis && !ext_exec ? "R7 ale" : "R1 ale"), ale, e_ale);
    check(ext_exec ? "R8 ale_oe" : (busy ? "R9 ale_oe" : "R7 ale_oe"), ale_oe, e_oe);
    check(second ? "R4 p0_sel" : "R3 p0_sel", p0_sel, e_p0);
    check((busy && kind != 2) ? "R5 p2_out" : "R6 p2_out", p2_out,
          (busy && kind != 2) ? ahi : p2_sfr);
    check("R2 ready", req_ready, (ph == 5) && !(busy && !second && (kind == 1 || kind == 2)));
  endtask

  task automatic wait_ready();
    while (!req_ready) @(negedge clk);
  endtask

  task automatic idle_slot();
    wait_ready();
    for (int p = 0; p < 6; p++) begin
      @(negedge clk);
      check_phase(0, 2'd0, 0, p, 8'h00);
    end
  endtask

  task automatic issue(logic [27:0] v);
    logic [1:0] k;
    int nslots;
    k = v[27:26];
    @(negedge clk);
    req_kind = k; req_addr = v[25:10]; p2_sfr = v[9:2];
    ale_dis = v[1]; ext_exec = v[0]; req_valid = 1'b1;
    // R2: ready stays low until phase 5, request held
    while (!req_ready) begin
      check("R2 ready low", {30'd0, ale_oe, req_ready}, {30'd0, ale_oe, 1'b0});
      @(negedge clk);
    end
    nslots = (k == 1 || k == 2) ? 2 : 1;
    for (int s = 0; s < nslots; s++)
      for (int p = 0; p < 6; p++) begin
        @(negedge clk);
        req_valid = 1'b0;
        req_addr = 16'h0000;
        check_phase(1, k, s == 1, p, v[25:18]);
      end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failed++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    // R10: values while held in reset
    #7;
    check("R10 ale", ale, 1'b1);
    check("R10 ale_oe", ale_oe, 1'b1);
    check("R10 ready", req_ready, 1'b0);
    check("R10 p0_sel", p0_sel, 2'd0);
    check("R10 p2_out", p2_out, 8'h5A);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R10 phase1 ale", ale, 1'b1);
    @(negedge clk); check("R10 phase2 ale", ale, 1'b0);
    repeat (2) @(negedge clk);
    check("R10 phase4 ready", req_ready, 1'b0);
    @(negedge clk); check("R10 phase5 ready", req_ready, 1'b1);

    // vector table
    for (int i = 0; i < NV; i++) issue(VEC[i]);

    // R7: idle with disable set, weak high
    ale_dis = 1; ext_exec = 0; p2_sfr = 8'hA7;
    idle_slot();
    // R8: idle with disable set but external execution
    ext_exec = 1;
    idle_slot();
    // R1: idle free-running
    ale_dis = 0; ext_exec = 0;
    idle_slot();
    // R6/R9: 8-bit pointer access under disable
    issue({2'd2, 16'h3355, 8'hE1, 1'b1, 1'b0});
    // back-to-back requests
    issue({2'd1, 16'hAB00, 8'h0F, 1'b0, 1'b0});
    issue({2'd3, 16'h00FF, 8'h0F, 1'b0, 1'b0});

    // R10: reset mid-slot restarts phase
    @(negedge clk); @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    check("R10 mid reset ale", ale, 1'b1);
    check("R10 mid reset ready", req_ready, 1'b0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check("R10 restart phase5 ready", req_ready, 1'b1);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule